// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache that turns virtual page numbers into physical frame numbers. Every slot is stamped with the address-space identifier of the process that owns the mapping. Translations from several processes can therefore share the cache, and a context switch does not have to empty it. A lookup presents a page number, the current identifier and an access kind. All slots are compared at once. One clock later the block reports exactly one of three outcomes: a hit with the frame number, a miss, or a permission fault with the frame number.

After a miss, an external table walker writes the missing mapping through the fill port. A fill uses the lowest-numbered empty slot when one exists. Otherwise it evicts the slot named by a rotating pointer, and that pointer steps over pinned ("wired") slots. Software can empty the cache completely, or only the slots of one identifier. Wired slots survive both kinds of flush.

Top module: `asid_tlb`

## Requirements
- R1: A lookup request is answered exactly one cycle later with `res_valid` high and exactly one of `res_hit`, `res_miss`, `res_fault` high. All four are low in cycles that follow no request.
- R2: A slot matches only when it is valid and both its page number and its identifier equal the request. A permitted match returns the slot's frame number on `res_pfn`.
- R3: When no slot matches, the block reports a miss with `res_pfn` equal to zero.
- R4: A fill becomes visible from the next cycle. A lookup issued in the same cycle as the fill sees the old contents, and later lookups of the filled page hit.
- R5: When at least one slot is empty, a fill that matches no slot takes the lowest-indexed empty slot and evicts nothing.
- R6: `lk_acc` is encoded as 00 read, 01 write, 10 execute, 11 read. A write needs the slot's write bit, and an execute needs its execute bit. A read is always allowed. A matching lookup whose access is not allowed reports a fault and still returns the frame number.
- R7: When all slots are valid, a fill evicts the first non-wired slot found by searching upward, with wraparound, from a rotating pointer. The pointer then moves to the slot after the victim. The pointer starts at slot 0 after reset and moves only on such an eviction.
- R8: A fill that matches no slot and finds every slot wired is dropped. `fill_err` pulses high in the next cycle and the contents stay unchanged.
- R9: `flush_all` invalidates every non-wired slot. `flush_id_en` invalidates the non-wired slots whose identifier equals `flush_id`. Wired slots stay valid through both.
- R10: A fill whose page number and identifier equal those of a valid slot overwrites that slot in place (frame, permissions and wired flag). No second copy is created and no other slot is evicted.
- R11: A fill presented in the same cycle as either flush is discarded and raises no error.
- R12: After reset, every slot is empty and every result output and `fill_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_id | input | ID_W | Identifier of the requesting address space |
| lk_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 read |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Translation found and access allowed |
| res_miss | output | 1 | No matching slot |
| res_fault | output | 1 | Translation found but access denied |
| res_pfn | output | PFN_W | Frame number (zero on a miss) |
| fill_valid | input | 1 | Write a mapping |
| fill_vpn | input | VPN_W | Page number of the mapping |
| fill_id | input | ID_W | Identifier of the mapping |
| fill_pfn | input | PFN_W | Frame number of the mapping |
| fill_wr | input | 1 | Write permitted |
| fill_ex | input | 1 | Execute permitted |
| fill_wired | input | 1 | Pin the slot against eviction and flush |
| fill_err | output | 1 | Previous-cycle fill dropped because every slot is wired |
| flush_all | input | 1 | Invalidate all non-wired slots |
| flush_id_en | input | 1 | Invalidate the non-wired slots of one identifier |
| flush_id | input | ID_W | Identifier targeted by `flush_id_en` |

## Verification
The bench goes after the cases where a plausible design slips:
- A lookup in the same cycle as a fill of the same page must still miss. A design that forwards the fill would report an early hit.
- A refill of an existing page must replace the old frame. A design that adds a duplicate would return a stale or OR-merged frame.
- When the rotating pointer sits on or next to a wired slot, a design that does not skip wired slots, or that moves the pointer on every fill, would evict the wrong page. Later lookups then hit where a miss is expected, or the reverse.
- Fills against a fully wired cache must raise the error flag and leave the contents untouched.
- A flush issued together with a fill must win over the fill.
- Each flush must spare wired slots and, for the per-identifier flush, the slots of other identifiers.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef struct packed {
    logic wr;
    logic ex;
  } perm_t;

  // Read (and the spare code) is always allowed; write and execute need their bit.
  function automatic logic perm_allows(perm_t p, logic [1:0] acc);
    case (acc)
      ACC_WRITE: return p.wr;
      ACC_EXEC:  return p.ex;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ID_W   = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            ent_valid,
  input  logic [N-1:0][VPN_W-1:0] ent_vpn,
  input  logic [N-1:0][ID_W-1:0]  ent_id,
  input  logic [VPN_W-1:0]        key_vpn,
  input  logic [ID_W-1:0]         key_id,
  output logic [N-1:0]            hit_vec,
  output logic                    any_hit,
  output logic [IDX_W-1:0]        hit_idx
);

  // One comparator per slot, all working in parallel.
  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    assign hit_vec[gi] = ent_valid[gi] && (ent_vpn[gi] == key_vpn) && (ent_id[gi] == key_id);
  end

  assign any_hit = |hit_vec;

  // Encode the matching slot; at most one bit is set because fills never duplicate.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N      = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     ent_valid,
  input  logic [N-1:0]     ent_wired,
  input  logic [IDX_W-1:0] rr_ptr,
  output logic             free_found,
  output logic [IDX_W-1:0] free_idx,
  output logic             evict_found,
  output logic [IDX_W-1:0] evict_idx
);

  // Lowest-indexed empty slot.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!free_found && !ent_valid[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  // First non-wired slot at or above the pointer, wrapping around.
  always_comb begin
    int j;
    evict_found = 1'b0;
    evict_idx   = '0;
    for (int k = 0; k < N; k++) begin
      j = int'(rr_ptr) + k;
      if (j >= N) j = j - N;
      if (!evict_found && !ent_wired[j]) begin
        evict_found = 1'b1;
        evict_idx   = IDX_W'(j);
      end
    end
  end

endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ID_W   = 8,
  parameter int PFN_W  = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [VPN_W-1:0]        wr_vpn,
  input  logic [ID_W-1:0]         wr_id,
  input  logic [PFN_W-1:0]        wr_pfn,
  input  perm_t                   wr_perm,
  input  logic                    wr_wired,
  input  logic [N-1:0]            clr_mask,
  input  logic                    rr_adv,
  input  logic [IDX_W-1:0]        rr_next,
  output logic [N-1:0]            ent_valid,
  output logic [N-1:0]            ent_wired,
  output logic [N-1:0][VPN_W-1:0] ent_vpn,
  output logic [N-1:0][ID_W-1:0]  ent_id,
  output logic [N-1:0][PFN_W-1:0] ent_pfn,
  output perm_t [N-1:0]           ent_perm,
  output logic [IDX_W-1:0]        rr_ptr
);

  logic [N-1:0]     valid_q, valid_d;
  logic [N-1:0]     wired_q, wired_d;
  logic [IDX_W-1:0] rr_q, rr_d;

  logic [N-1:0][VPN_W-1:0] vpn_q;
  logic [N-1:0][ID_W-1:0]  id_q;
  logic [N-1:0][PFN_W-1:0] pfn_q;
  perm_t [N-1:0]           perm_q;

  // Control state: next-state logic.
  always_comb begin
    valid_d = valid_q & ~clr_mask;
    wired_d = wired_q;
    if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
      wired_d[wr_idx] = wr_wired;
    end
    rr_d = rr_adv ? rr_next : rr_q;
  end

  // Control state: registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      wired_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      wired_q <= wired_d;
      rr_q    <= rr_d;
    end
  end

  // Payload: written only on a fill and never reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= wr_vpn;
      id_q[wr_idx]   <= wr_id;
      pfn_q[wr_idx]  <= wr_pfn;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  assign ent_valid = valid_q;
  assign ent_wired = wired_q;
  assign ent_vpn   = vpn_q;
  assign ent_id    = id_q;
  assign ent_pfn   = pfn_q;
  assign ent_perm  = perm_q;
  assign rr_ptr    = rr_q;

  AST_WIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(valid_q & wired_q) & ~valid_q) == '0)); // R9

  AST_RR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_adv |=> $stable(rr_q)); // R7

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int ID_W  = 8,
  parameter int PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ID_W-1:0]  lk_id,
  input  logic [1:0]       lk_acc,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_miss,
  output logic             res_fault,
  output logic [PFN_W-1:0] res_pfn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [ID_W-1:0]  fill_id,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_wr,
  input  logic             fill_ex,
  input  logic             fill_wired,
  output logic             fill_err,
  input  logic             flush_all,
  input  logic             flush_id_en,
  input  logic [ID_W-1:0]  flush_id
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]            ent_valid, ent_wired;
  logic [N-1:0][VPN_W-1:0] ent_vpn;
  logic [N-1:0][ID_W-1:0]  ent_id;
  logic [N-1:0][PFN_W-1:0] ent_pfn;
  perm_t [N-1:0]           ent_perm;
  logic [IDX_W-1:0]        rr_ptr;

  // ---------------- lookup path ----------------
  logic [N-1:0]     lk_hit_vec;
  logic             lk_any;
  logic [IDX_W-1:0] lk_idx;

  tlb_match #(.N(N), .VPN_W(VPN_W), .ID_W(ID_W)) u_lk_match (
    .ent_valid (ent_valid),
    .ent_vpn   (ent_vpn),
    .ent_id    (ent_id),
    .key_vpn   (lk_vpn),
    .key_id    (lk_id),
    .hit_vec   (lk_hit_vec),
    .any_hit   (lk_any),
    .hit_idx   (lk_idx)
  );

  logic             lk_ok;
  logic             res_valid_d, res_hit_d, res_miss_d, res_fault_d;
  logic [PFN_W-1:0] res_pfn_d;

  always_comb begin
    lk_ok       = perm_allows(ent_perm[lk_idx], lk_acc);
    res_valid_d = lk_valid;
    res_hit_d   = lk_valid && lk_any && lk_ok;
    res_fault_d = lk_valid && lk_any && !lk_ok;
    res_miss_d  = lk_valid && !lk_any;
    res_pfn_d   = (lk_valid && lk_any) ? ent_pfn[lk_idx] : '0;
  end

  // ---------------- fill path ----------------
  logic [N-1:0]     fl_hit_vec;
  logic             fl_any;
  logic [IDX_W-1:0] fl_idx;

  tlb_match #(.N(N), .VPN_W(VPN_W), .ID_W(ID_W)) u_fill_match (
    .ent_valid (ent_valid),
    .ent_vpn   (ent_vpn),
    .ent_id    (ent_id),
    .key_vpn   (fill_vpn),
    .key_id    (fill_id),
    .hit_vec   (fl_hit_vec),
    .any_hit   (fl_any),
    .hit_idx   (fl_idx)
  );

  logic             free_found, evict_found;
  logic [IDX_W-1:0] free_idx, evict_idx;

  tlb_victim #(.N(N)) u_victim (
    .ent_valid   (ent_valid),
    .ent_wired   (ent_wired),
    .rr_ptr      (rr_ptr),
    .free_found  (free_found),
    .free_idx    (free_idx),
    .evict_found (evict_found),
    .evict_idx   (evict_idx)
  );

  logic             flush_act, fill_go;
  logic             wr_en, rr_adv, fill_err_d;
  logic [IDX_W-1:0] wr_idx, rr_next;
  logic [N-1:0]     clr_mask;

  always_comb begin
    flush_act  = flush_all || flush_id_en;
    fill_go    = fill_valid && !flush_act;
    wr_en      = 1'b0;
    wr_idx     = '0;
    rr_adv     = 1'b0;
    fill_err_d = 1'b0;
    rr_next    = (int'(evict_idx) == N - 1) ? '0 : evict_idx + 1'b1;
    if (fill_go) begin
      if (fl_any) begin
        wr_en  = 1'b1;
        wr_idx = fl_idx;
      end else if (free_found) begin
        wr_en  = 1'b1;
        wr_idx = free_idx;
      end else if (evict_found) begin
        wr_en  = 1'b1;
        wr_idx = evict_idx;
        rr_adv = 1'b1;
      end else begin
        fill_err_d = 1'b1;
      end
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_clr
    assign clr_mask[gi] = !ent_wired[gi] &&
                          (flush_all || (flush_id_en && (ent_id[gi] == flush_id)));
  end

  tlb_store #(.N(N), .VPN_W(VPN_W), .ID_W(ID_W), .PFN_W(PFN_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_vpn    (fill_vpn),
    .wr_id     (fill_id),
    .wr_pfn    (fill_pfn),
    .wr_perm   ('{wr: fill_wr, ex: fill_ex}),
    .wr_wired  (fill_wired),
    .clr_mask  (clr_mask),
    .rr_adv    (rr_adv),
    .rr_next   (rr_next),
    .ent_valid (ent_valid),
    .ent_wired (ent_wired),
    .ent_vpn   (ent_vpn),
    .ent_id    (ent_id),
    .ent_pfn   (ent_pfn),
    .ent_perm  (ent_perm),
    .rr_ptr    (rr_ptr)
  );

  // ---------------- result registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_fault <= 1'b0;
      res_pfn   <= '0;
      fill_err  <= 1'b0;
    end else begin
      res_valid <= res_valid_d;
      res_hit   <= res_hit_d;
      res_miss  <= res_miss_d;
      res_fault <= res_fault_d;
      res_pfn   <= res_pfn_d;
      fill_err  <= fill_err_d;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones({res_hit, res_miss, res_fault}) == 1)); // R1

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid); // R1

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> (res_pfn == '0)); // R3

  AST_ERR_FULL_WIRED: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> $past(&ent_wired)); // R8

  AST_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec)); // R10

  AST_VICTIM_UNWIRED: assert property (@(posedge clk) disable iff (!rst_n)
    rr_adv |-> !ent_wired[evict_idx]); // R7

  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fl_any && !(&ent_valid)) |-> !ent_valid[wr_idx]); // R5

  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && flush_act) |=> !fill_err); // R11

endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;

  localparam int N     = 16;
  localparam int VPN_W = 20;
  localparam int ID_W  = 8;
  localparam int PFN_W = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             lk_valid;
  logic [VPN_W-1:0] lk_vpn;
  logic [ID_W-1:0]  lk_id;
  logic [1:0]       lk_acc;
  logic             res_valid, res_hit, res_miss, res_fault;
  logic [PFN_W-1:0] res_pfn;
  logic             fill_valid;
  logic [VPN_W-1:0] fill_vpn;
  logic [ID_W-1:0]  fill_id;
  logic [PFN_W-1:0] fill_pfn;
  logic             fill_wr, fill_ex, fill_wired;
  logic             fill_err;
  logic             flush_all, flush_id_en;
  logic [ID_W-1:0]  flush_id;

  always #5 clk = ~clk;

  asid_tlb #(.N(N), .VPN_W(VPN_W), .ID_W(ID_W), .PFN_W(PFN_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_id(lk_id), .lk_acc(lk_acc),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_fault(res_fault), .res_pfn(res_pfn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_id(fill_id),
    .fill_pfn(fill_pfn), .fill_wr(fill_wr), .fill_ex(fill_ex),
    .fill_wired(fill_wired), .fill_err(fill_err),
    .flush_all(flush_all), .flush_id_en(flush_id_en), .flush_id(flush_id)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R12";
  bit finished = 1'b0;

  // Behavioural reference state.
  bit               m_valid [N];
  bit               m_wired [N];
  logic [VPN_W-1:0] m_vpn   [N];
  logic [ID_W-1:0]  m_id    [N];
  logic [PFN_W-1:0] m_pfn   [N];
  bit               m_wr    [N];
  bit               m_ex    [N];
  int               m_rr;

  bit               e_valid, e_hit, e_miss, e_fault, e_err;
  logic [PFN_W-1:0] e_pfn;

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0;
      m_wired[i] = 0;
    end
    m_rr = 0;
    e_valid = 0; e_hit = 0; e_miss = 0; e_fault = 0; e_err = 0; e_pfn = '0;
  endtask

  // Prediction for the next edge from the inputs now applied.
  task automatic model_step();
    int  idx;
    bit  ok;
    e_valid = lk_valid; e_hit = 0; e_miss = 0; e_fault = 0; e_pfn = '0; e_err = 0;
    if (lk_valid) begin
      idx = -1;
      for (int i = 0; i < N; i++)
        if (m_valid[i] && m_vpn[i] == lk_vpn && m_id[i] == lk_id) idx = i;
      if (idx < 0) e_miss = 1;
      else begin
        ok = (lk_acc == 2'b01) ? m_wr[idx] : (lk_acc == 2'b10) ? m_ex[idx] : 1'b1;
        e_hit   = ok;
        e_fault = !ok;
        e_pfn   = m_pfn[idx];
      end
    end
    if (flush_all || flush_id_en) begin
      for (int i = 0; i < N; i++)
        if (!m_wired[i] && (flush_all || m_id[i] == flush_id)) m_valid[i] = 0;
    end else if (fill_valid) begin
      idx = -1;
      for (int i = 0; i < N; i++)
        if (m_valid[i] && m_vpn[i] == fill_vpn && m_id[i] == fill_id) idx = i;
      if (idx < 0)
        for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) idx = i;
      if (idx < 0) begin
        for (int k = 0; k < N; k++) begin
          if (idx < 0 && !m_wired[(m_rr + k) % N]) idx = (m_rr + k) % N;
        end
        if (idx >= 0) m_rr = (idx + 1) % N;
      end
      if (idx < 0) e_err = 1;
      else begin
        m_valid[idx] = 1; m_wired[idx] = fill_wired;
        m_vpn[idx] = fill_vpn; m_id[idx] = fill_id; m_pfn[idx] = fill_pfn;
        m_wr[idx] = fill_wr; m_ex[idx] = fill_ex;
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (res_valid !== e_valid || res_hit !== e_hit || res_miss !== e_miss ||
        res_fault !== e_fault || res_pfn !== e_pfn || fill_err !== e_err) begin
      errors++;
      $display("FAIL %s t=%0t actual v%0b h%0b m%0b f%0b pfn=%h err%0b expected v%0b h%0b m%0b f%0b pfn=%h err%0b",
               tag, $time, res_valid, res_hit, res_miss, res_fault, res_pfn, fill_err,
               e_valid, e_hit, e_miss, e_fault, e_pfn, e_err);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_vpn = '0; lk_id = '0; lk_acc = 2'b00;
    fill_valid = 0; fill_vpn = '0; fill_id = '0; fill_pfn = '0;
    fill_wr = 0; fill_ex = 0; fill_wired = 0;
    flush_all = 0; flush_id_en = 0; flush_id = '0;
  endtask

  // Apply current inputs for one clock, then check after the edge.
  task automatic tick();
    model_step();
    @(posedge clk);
    #2;
    compare();
    idle_inputs();
  endtask

  task automatic lookup(int vpn, int id, int acc);
    lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_id = ID_W'(id); lk_acc = 2'(acc);
    tick();
  endtask

  task automatic fill(int vpn, int id, int pfn, bit wr, bit ex, bit wired);
    fill_valid = 1; fill_vpn = VPN_W'(vpn); fill_id = ID_W'(id); fill_pfn = PFN_W'(pfn);
    fill_wr = wr; fill_ex = ex; fill_wired = wired;
    tick();
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle_inputs();
    model_reset();
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    do_reset();
    tag = "R12"; compare();                      // R12 reset state
    tag = "R12"; lookup(5, 1, 0);                 // R12 empty after reset

    tag = "R3"; lookup(9, 2, 0);                  // R3 miss, zero frame
    // R4: lookup in the same cycle as the fill sees old contents
    tag = "R4";
    fill_valid = 1; fill_vpn = 20'd5; fill_id = 8'd1; fill_pfn = 20'hABCDE;
    fill_wr = 1; fill_ex = 0; fill_wired = 0;
    lk_valid = 1; lk_vpn = 20'd5; lk_id = 8'd1; lk_acc = 2'b00;
    tick();
    tag = "R4"; lookup(5, 1, 0);
    tag = "R2"; lookup(5, 2, 0);                  // other identifier misses
    tag = "R2"; lookup(6, 1, 0);
    tag = "R6"; lookup(5, 1, 1);                  // write allowed
    tag = "R6"; lookup(5, 1, 2);                  // exec fault
    tag = "R6"; lookup(5, 1, 3);                  // spare code reads
    tag = "R10"; fill(5, 1, 'h12345, 0, 1, 0);    // overwrite in place
    tag = "R10"; lookup(5, 1, 2);
    tag = "R10"; lookup(5, 1, 1);
    // R11: flush and fill together, fill dropped
    tag = "R11";
    flush_id_en = 1; flush_id = 8'd3;
    fill_valid = 1; fill_vpn = 20'd6; fill_id = 8'd1; fill_pfn = 20'h00666;
    tick();
    tag = "R11"; lookup(6, 1, 0);
    // R9: wired survives, others cleared
    tag = "R9"; fill(7, 1, 'h777, 1, 1, 1);
    tag = "R9"; fill(8, 2, 'h888, 1, 1, 0);
    tag = "R9"; flush_id_en = 1; flush_id = 8'd1; tick();
    tag = "R9"; lookup(5, 1, 0);
    tag = "R9"; lookup(7, 1, 0);
    tag = "R9"; lookup(8, 2, 0);
    tag = "R9"; flush_all = 1; tick();
    tag = "R9"; lookup(8, 2, 0);
    tag = "R9"; lookup(7, 1, 0);
    // R8: fill every slot wired, then one more
    for (int i = 0; i < N - 1; i++) begin
      tag = "R5"; fill(100 + i, 4, 'h100 + i, 0, 0, 1);
    end
    tag = "R8"; fill(300, 4, 'h300, 1, 1, 0);
    tag = "R8"; lookup(300, 4, 0);
    tag = "R8"; lookup(100, 4, 0);
    tag = "R10"; fill(100, 4, 'h999, 1, 1, 1);   // overwrite still possible
    tag = "R10"; lookup(100, 4, 0);

    // R7: round-robin with a wired neighbour
    do_reset();
    tag = "R12"; compare();
    tag = "R5"; fill(0, 1, 'h10, 1, 1, 0);
    tag = "R5"; fill(1, 1, 'h11, 1, 1, 1);
    for (int i = 2; i < N; i++) begin
      tag = "R5"; fill(i, 1, 'h10 + i, 1, 1, 0);
    end
    tag = "R7"; fill(200, 1, 'h200, 1, 1, 0);    // evicts slot 0
    tag = "R7"; lookup(0, 1, 0);
    tag = "R7"; fill(201, 1, 'h201, 1, 1, 0);    // skips wired slot 1, evicts slot 2
    tag = "R7"; lookup(1, 1, 0);
    tag = "R7"; lookup(2, 1, 0);
    tag = "R7"; lookup(3, 1, 0);
    tag = "R7"; fill(202, 1, 'h202, 1, 1, 0);    // evicts slot 3
    tag = "R7"; lookup(3, 1, 0);
    tag = "R7"; lookup(4, 1, 0);

    // Mixed traffic checked every clock against the reference.
    do_reset();
    for (int it = 0; it < 4000; it++) begin
      tag = "R1";
      lk_valid = ($urandom_range(0, 3) != 0);
      lk_vpn = VPN_W'($urandom_range(0, 9)); lk_id = ID_W'($urandom_range(0, 2));
      lk_acc = 2'($urandom_range(0, 3));
      fill_valid = ($urandom_range(0, 2) == 0);
      fill_vpn = VPN_W'($urandom_range(0, 9)); fill_id = ID_W'($urandom_range(0, 2));
      fill_pfn = PFN_W'($urandom); fill_wr = 1'($urandom); fill_ex = 1'($urandom);
      fill_wired = ($urandom_range(0, 15) == 0);
      flush_all = ($urandom_range(0, 99) == 0);
      flush_id_en = ($urandom_range(0, 49) == 0);
      flush_id = ID_W'($urandom_range(0, 2));
      tick();
    end

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule